// File: doc/BRIEF.md
# Single-Precision Round and Pack Unit

This unit turns an unpacked binary32 result into its final 32-bit encoding. An arithmetic datapath supplies a sign, a signed unbiased exponent and a 27-bit working mantissa. In that mantissa, bit 26 is the leading one, bits 25..3 are the fraction and bits 2..0 hold the extra precision left over from the operation. The unit rounds the mantissa in one of four directions and renormalises when rounding carries out. It shifts tiny values into denormal form or flushes them, and it saturates large values to infinity or to the largest finite magnitude. It also reports the inexact, underflow and overflow conditions for that one operation.

The caller asserts `in_valid` together with the operands and the mode controls. One clock later the packed word and its three flags appear, marked by `out_valid`. A zero mantissa is not a legal input: the leading bit must be set and nothing may sit above bit 26. Zeros, NaNs and infinities on the input side belong to the caller.

Top module: `sp_round_pack`

## Requirements
- R1: After a synchronous reset `out_valid`, `out_word` and all flags are 0. `out_valid` is high exactly one cycle after each cycle with `in_valid` high. The word and flags registered then describe only that operation.
- R2: An input with exponent in -126..127 and zero low three mantissa bits packs exactly as {sign, exponent+127, mantissa[25:3]} with no flag raised.
- R3: With `rmode`=0 (nearest), a nonzero tail is rounded to nearest. A tail of exactly binary 100 rounds toward an even result fraction. Inexact is raised.
- R4: With a nonzero tail, `rmode`=1 truncates. `rmode`=2 rounds the magnitude up only for a positive sign. `rmode`=3 rounds the magnitude up only for a negative sign. Inexact is raised.
- R5: When rounding carries out of bit 26, the significand is halved and the exponent grows by one.
- R6: A final exponent above 127 raises overflow and inexact. The result is infinity for nearest, for up with a positive sign and for down with a negative sign. Otherwise it is the largest finite magnitude 0x7F7FFFFF with the input sign.
- R7: An exponent below -126 (flush off) makes the mantissa shift right by -126 minus the exponent, with every lost one kept in bit 0. The value is then rounded at exponent -126 and packed with exponent field 0 if bit 26 is then clear. A nonzero tail after the shift raises inexact, and also underflow when bit 26 is clear.
- R8: An exact denormal result raises underflow only when `uf_trap_en` is 1.
- R9: At exponent -127 with flush off, an input whose rounding in the chosen mode would carry out of bit 26 gives the smallest normal 0x00800000 (with its sign). Only inexact is raised.
- R10: With `flush_en`=1 and exponent below -126, underflow and inexact are raised. The result is ±0.0 with the input sign, except that up with a positive sign gives +0x00800000 and down with a negative sign gives 0x80800000.
- R11: Exponents far below -126, including the most negative encodable, collapse the whole mantissa into the sticky bit. The result is then zero or the smallest denormal, as the mode directs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operation present on the inputs |
| in_sign | input | 1 | Sign of the value |
| in_exp | input | EXP_W | Unbiased exponent, two's complement |
| in_mant | input | 27 | Leading one at bit 26, fraction 25..3, tail 2..0 |
| rmode | input | 2 | 0 nearest-even, 1 toward zero, 2 upward, 3 downward |
| flush_en | input | 1 | Flush tiny values instead of building denormals |
| uf_trap_en | input | 1 | Also flag underflow for exact denormal results |
| out_valid | output | 1 | Result registered this cycle |
| out_word | output | 32 | Packed binary32 result |
| flag_inexact | output | 1 | Result differs from the exact value |
| flag_underflow | output | 1 | Tiny result per R7, R8, R10 |
| flag_overflow | output | 1 | Exponent range exceeded |

## Verification
The hardest case to reach is the boundary at exponent -127. Whether the result is a promoted smallest normal or a true denormal depends on the rounding mode and the sign acting on an all-ones mantissa. The stimulus table drives that same mantissa at -127 under nearest, toward zero and downward with a negative sign, and so lands on both outcomes. Right beside those entries it places the same input with flush on, which shows that flushing takes priority. Sticky collapse is reached with exponents of -300 and -512, where the shift distance is far larger than the mantissa.

// File: rtl/sp_rp_pkg.sv
package sp_rp_pkg;

  localparam int MANT_W  = 27;   // leading one + fraction + 3-bit tail
  localparam int TAIL_W  = 3;
  localparam int FRAC_W  = MANT_W - 1 - TAIL_W;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int EFLD_W  = 8;
  localparam int EBIAS   = 127;
  localparam int EMIN    = -126;
  localparam int EMAX    = 127;
  localparam int SHIFT_W = $clog2(MANT_W + 1);

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  localparam logic [30:0] MAG_INF   = 31'h7F80_0000;
  localparam logic [30:0] MAG_MAXF  = 31'h7F7F_FFFF;
  localparam logic [30:0] MAG_MINN  = 31'h0080_0000;

  // amount added to the working mantissa for a given tail, sign and mode
  function automatic logic [MANT_W:0] rp_round(input logic sgn,
                                               input logic [MANT_W-1:0] m,
                                               input rmode_e md);
    logic [MANT_W:0] inc;
    inc = '0;
    if (m[TAIL_W-1:0] != '0) begin
      unique case (md)
        RM_NEAR: inc = (MANT_W+1)'(3) + (MANT_W+1)'(m[TAIL_W]);
        RM_ZERO: inc = '0;
        RM_UP:   inc = sgn ? '0 : (MANT_W+1)'(8);
        RM_DOWN: inc = sgn ? (MANT_W+1)'(8) : '0;
      endcase
    end
    return {1'b0, m} + inc;
  endfunction

  // right shift that folds every lost one into bit 0
  function automatic logic [MANT_W-1:0] rp_sticky_shr(input logic [MANT_W-1:0] m,
                                                      input logic [SHIFT_W-1:0] sh);
    logic [MANT_W-1:0] lost_mask;
    lost_mask = ~({MANT_W{1'b1}} << sh);
    return (m >> sh) | {{(MANT_W-1){1'b0}}, |(m & lost_mask)};
  endfunction

  // directed saturation choices
  function automatic logic pick_inf(input logic sgn, input rmode_e md);
    return (md == RM_NEAR) || (md == RM_UP && !sgn) || (md == RM_DOWN && sgn);
  endfunction

  function automatic logic pick_minnorm(input logic sgn, input rmode_e md);
    return (md == RM_UP && !sgn) || (md == RM_DOWN && sgn);
  endfunction

endpackage

// File: rtl/rp_tiny_align.sv
module rp_tiny_align
  import sp_rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                     sgn,
  input  logic signed [EXP_W-1:0]  exp_in,
  input  logic [MANT_W-1:0]        mant_in,
  input  rmode_e                   md,
  input  logic                     flush_en,
  output logic signed [EXP_W-1:0]  exp_al,
  output logic [MANT_W-1:0]        mant_al,
  output logic                     flush_hit,
  output logic [31:0]              flush_word,
  output logic                     promote_hit
);

  logic            is_tiny;
  logic            at_edge;
  logic [MANT_W:0] pre_rnd;
  logic [3:0]      pre_lsb_unused;
  logic [SHIFT_W-1:0] sh_amt;
  int              sh_full;

  assign is_tiny   = (int'(exp_in) < EMIN);
  assign at_edge   = (int'(exp_in) == EMIN - 1);
  assign pre_rnd   = rp_round(sgn, mant_in, md);
  assign pre_lsb_unused = pre_rnd[3:0];

  assign flush_hit   = is_tiny && flush_en;
  assign promote_hit = at_edge && !flush_en && pre_rnd[MANT_W];

  always_comb begin
    sh_full = EMIN - int'(exp_in);
    if (sh_full > MANT_W) sh_amt = SHIFT_W'(MANT_W);
    else                  sh_amt = SHIFT_W'(sh_full);
  end

  always_comb begin
    exp_al  = exp_in;
    mant_al = mant_in;
    if (promote_hit) begin
      exp_al  = EXP_W'(EMIN);
      mant_al = {pre_rnd[MANT_W:TAIL_W+1], {TAIL_W{1'b0}}};
    end else if (is_tiny) begin
      exp_al  = EXP_W'(EMIN);
      mant_al = rp_sticky_shr(mant_in, sh_amt);
    end
  end

  assign flush_word = {sgn, pick_minnorm(sgn, md) ? MAG_MINN : 31'd0};

endmodule

// File: rtl/rp_round_stage.sv
module rp_round_stage
  import sp_rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    sgn,
  input  logic signed [EXP_W-1:0] exp_al,
  input  logic [MANT_W-1:0]       mant_al,
  input  rmode_e                  md,
  output logic [SIG_W-1:0]        sig,
  output logic signed [EXP_W:0]   exp_rd,
  output logic                    rnd_inexact,
  output logic                    rnd_tiny,
  output logic                    carry_hit
);

  logic [MANT_W:0]    rounded;
  logic [TAIL_W-1:0]  rnd_lsb_unused;

  assign rounded        = rp_round(sgn, mant_al, md);
  assign rnd_lsb_unused = rounded[TAIL_W-1:0];
  assign carry_hit      = rounded[MANT_W];

  assign sig = carry_hit ? rounded[MANT_W:TAIL_W+1] : rounded[MANT_W-1:TAIL_W];
  assign exp_rd = {exp_al[EXP_W-1], exp_al} + {{EXP_W{1'b0}}, carry_hit};

  assign rnd_inexact = |mant_al[TAIL_W-1:0];
  assign rnd_tiny    = rnd_inexact && !mant_al[MANT_W-1];

endmodule

// File: rtl/rp_pack.sv
module rp_pack
  import sp_rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                  sgn,
  input  logic [SIG_W-1:0]      sig,
  input  logic signed [EXP_W:0] exp_rd,
  input  rmode_e                md,
  output logic [31:0]           word,
  output logic                  ovf_hit,
  output logic                  denorm_hit
);

  logic [EFLD_W-1:0] efield;

  assign ovf_hit    = (int'(exp_rd) > EMAX);
  assign denorm_hit = !sig[SIG_W-1];
  assign efield     = EFLD_W'(int'(exp_rd) + EBIAS);

  always_comb begin
    if (ovf_hit)
      word = {sgn, pick_inf(sgn, md) ? MAG_INF : MAG_MAXF};
    else if (denorm_hit)
      word = {sgn, {EFLD_W{1'b0}}, sig[FRAC_W-1:0]};
    else
      word = {sgn, efield, sig[FRAC_W-1:0]};
  end

endmodule

// File: rtl/sp_round_pack.sv
module sp_round_pack
  import sp_rp_pkg::*;
#(
  parameter int EXP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic                    in_sign,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [26:0]             in_mant,
  input  logic [1:0]              rmode,
  input  logic                    flush_en,
  input  logic                    uf_trap_en,
  output logic                    out_valid,
  output logic [31:0]             out_word,
  output logic                    flag_inexact,
  output logic                    flag_underflow,
  output logic                    flag_overflow
);

  rmode_e                  md;
  logic signed [EXP_W-1:0] exp_al;
  logic [MANT_W-1:0]       mant_al;
  logic                    flush_hit;
  logic [31:0]             flush_word;
  logic                    promote_hit;
  logic [SIG_W-1:0]        sig;
  logic signed [EXP_W:0]   exp_rd;
  logic                    rnd_inexact;
  logic                    rnd_tiny;
  logic                    carry_hit;
  logic [31:0]             pack_word;
  logic                    ovf_hit;
  logic                    denorm_hit;

  logic [31:0] nxt_word;
  logic        nxt_inexact;
  logic        nxt_underflow;
  logic        nxt_overflow;

  assign md = rmode_e'(rmode);

  rp_tiny_align #(.EXP_W(EXP_W)) u_align (
    .sgn        (in_sign),
    .exp_in     (in_exp),
    .mant_in    (in_mant),
    .md         (md),
    .flush_en   (flush_en),
    .exp_al     (exp_al),
    .mant_al    (mant_al),
    .flush_hit  (flush_hit),
    .flush_word (flush_word),
    .promote_hit(promote_hit)
  );

  rp_round_stage #(.EXP_W(EXP_W)) u_round (
    .sgn        (in_sign),
    .exp_al     (exp_al),
    .mant_al    (mant_al),
    .md         (md),
    .sig        (sig),
    .exp_rd     (exp_rd),
    .rnd_inexact(rnd_inexact),
    .rnd_tiny   (rnd_tiny),
    .carry_hit  (carry_hit)
  );

  rp_pack #(.EXP_W(EXP_W)) u_pack (
    .sgn       (in_sign),
    .sig       (sig),
    .exp_rd    (exp_rd),
    .md        (md),
    .word      (pack_word),
    .ovf_hit   (ovf_hit),
    .denorm_hit(denorm_hit)
  );

  always_comb begin
    if (flush_hit) begin
      nxt_word      = flush_word;
      nxt_inexact   = 1'b1;
      nxt_underflow = 1'b1;
      nxt_overflow  = 1'b0;
    end else begin
      nxt_word      = pack_word;
      nxt_overflow  = ovf_hit;
      nxt_inexact   = promote_hit || rnd_inexact || ovf_hit;
      nxt_underflow = rnd_tiny || (denorm_hit && !ovf_hit && uf_trap_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid      <= 1'b0;
      out_word       <= '0;
      flag_inexact   <= 1'b0;
      flag_underflow <= 1'b0;
      flag_overflow  <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_word       <= nxt_word;
        flag_inexact   <= nxt_inexact;
        flag_underflow <= nxt_underflow;
        flag_overflow  <= nxt_overflow;
      end
    end
  end

endmodule

// File: rtl/sp_round_pack_chk.sv
module sp_round_pack_chk #(
  parameter int EXP_W = 10
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic signed [EXP_W-1:0] in_exp,
  input logic [26:0]             in_mant,
  input logic                    flush_en,
  input logic                    promote_hit,
  input logic                    out_valid,
  input logic [31:0]             out_word,
  input logic                    flag_inexact,
  input logic                    flag_underflow,
  input logic                    flag_overflow
);

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_exact_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_mant[2:0] == 3'd0 && int'(in_exp) >= -126 && int'(in_exp) <= 127)
    |=> (!flag_inexact && !flag_underflow && !flag_overflow));

  p_ovf_saturate_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && flag_overflow) |->
    (flag_inexact && !flag_underflow &&
     (out_word[30:0] == 31'h7F80_0000 || out_word[30:0] == 31'h7F7F_FFFF)));

  p_promote_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && promote_hit) |=>
    (flag_inexact && !flag_underflow && out_word[30:0] == 31'h0080_0000));

  p_flush_flags_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && flush_en && int'(in_exp) < -126) |=>
    (flag_underflow && flag_inexact && !flag_overflow && out_word[22:1] == 22'd0));

endmodule

bind sp_round_pack sp_round_pack_chk #(.EXP_W(EXP_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .in_valid      (in_valid),
  .in_exp        (in_exp),
  .in_mant       (in_mant),
  .flush_en      (flush_en),
  .promote_hit   (promote_hit),
  .out_valid     (out_valid),
  .out_word      (out_word),
  .flag_inexact  (flag_inexact),
  .flag_underflow(flag_underflow),
  .flag_overflow (flag_overflow)
);

// File: tb/tb_sp_round_pack.sv
module tb_sp_round_pack;

  localparam int EXP_W = 10;

  logic                    clk = 1'b0;
  logic                    rst;
  logic                    in_valid;
  logic                    in_sign;
  logic signed [EXP_W-1:0] in_exp;
  logic [26:0]             in_mant;
  logic [1:0]              rmode;
  logic                    flush_en;
  logic                    uf_trap_en;
  logic                    out_valid;
  logic [31:0]             out_word;
  logic                    flag_inexact;
  logic                    flag_underflow;
  logic                    flag_overflow;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  sp_round_pack #(.EXP_W(EXP_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sign(in_sign),
    .in_exp(in_exp), .in_mant(in_mant), .rmode(rmode), .flush_en(flush_en),
    .uf_trap_en(uf_trap_en), .out_valid(out_valid), .out_word(out_word),
    .flag_inexact(flag_inexact), .flag_underflow(flag_underflow),
    .flag_overflow(flag_overflow)
  );

  // sign, exponent, mantissa, mode (0 near,1 zero,2 up,3 down), flush, trap,
  // expected word, expected {inexact, underflow, overflow}, requirement
  typedef struct packed {
    logic               s;
    logic signed [9:0]  e;
    logic [26:0]        m;
    logic [1:0]         rm;
    logic               fz;
    logic               ut;
    logic [31:0]        w;
    logic [2:0]         f;
    logic [3:0]         req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VECS [NV] = '{
    // R2 exact normals
    '{1'b0, 10'sd0,    27'h4000000, 2'd0, 1'b0, 1'b0, 32'h3F800000, 3'b000, 4'd2},
    '{1'b1, 10'sd5,    27'h6000000, 2'd1, 1'b0, 1'b0, 32'hC2400000, 3'b000, 4'd2},
    // R3 nearest-even
    '{1'b0, 10'sd0,    27'h4000004, 2'd0, 1'b0, 1'b0, 32'h3F800000, 3'b100, 4'd3},
    '{1'b0, 10'sd0,    27'h400000C, 2'd0, 1'b0, 1'b0, 32'h3F800002, 3'b100, 4'd3},
    '{1'b0, 10'sd0,    27'h4000005, 2'd0, 1'b0, 1'b0, 32'h3F800001, 3'b100, 4'd3},
    '{1'b0, 10'sd0,    27'h4000003, 2'd0, 1'b0, 1'b0, 32'h3F800000, 3'b100, 4'd3},
    // R4 directed modes
    '{1'b0, 10'sd0,    27'h400000F, 2'd1, 1'b0, 1'b0, 32'h3F800001, 3'b100, 4'd4},
    '{1'b0, 10'sd0,    27'h4000001, 2'd2, 1'b0, 1'b0, 32'h3F800001, 3'b100, 4'd4},
    '{1'b1, 10'sd0,    27'h4000001, 2'd2, 1'b0, 1'b0, 32'hBF800000, 3'b100, 4'd4},
    '{1'b1, 10'sd0,    27'h4000001, 2'd3, 1'b0, 1'b0, 32'hBF800001, 3'b100, 4'd4},
    '{1'b0, 10'sd0,    27'h4000001, 2'd3, 1'b0, 1'b0, 32'h3F800000, 3'b100, 4'd4},
    // R5 carry renormalisation
    '{1'b0, 10'sd0,    27'h7FFFFFF, 2'd0, 1'b0, 1'b0, 32'h40000000, 3'b100, 4'd5},
    '{1'b1, -10'sd3,   27'h7FFFFFF, 2'd2, 1'b0, 1'b0, 32'hBE7FFFFF, 3'b100, 4'd4},
    // R6 overflow by mode and sign
    '{1'b0, 10'sd128,  27'h4000000, 2'd0, 1'b0, 1'b0, 32'h7F800000, 3'b101, 4'd6},
    '{1'b1, 10'sd128,  27'h4000000, 2'd1, 1'b0, 1'b0, 32'hFF7FFFFF, 3'b101, 4'd6},
    '{1'b1, 10'sd128,  27'h4000000, 2'd2, 1'b0, 1'b0, 32'hFF7FFFFF, 3'b101, 4'd6},
    '{1'b0, 10'sd128,  27'h4000000, 2'd2, 1'b0, 1'b0, 32'h7F800000, 3'b101, 4'd6},
    '{1'b0, 10'sd128,  27'h4000000, 2'd3, 1'b0, 1'b0, 32'h7F7FFFFF, 3'b101, 4'd6},
    '{1'b1, 10'sd128,  27'h4000000, 2'd3, 1'b0, 1'b0, 32'hFF800000, 3'b101, 4'd6},
    '{1'b0, 10'sd127,  27'h7FFFFFF, 2'd0, 1'b0, 1'b0, 32'h7F800000, 3'b101, 4'd6},
    // R1 flags refreshed after an overflow; R2 largest finite exact
    '{1'b0, 10'sd127,  27'h7FFFFF8, 2'd0, 1'b0, 1'b0, 32'h7F7FFFFF, 3'b000, 4'd1},
    // R10 flush leaves the minimum normal exponent alone
    '{1'b0, -10'sd126, 27'h4000000, 2'd0, 1'b1, 1'b0, 32'h00800000, 3'b000, 4'd10},
    // R8 exact denormals, trap off and on
    '{1'b0, -10'sd127, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00400000, 3'b000, 4'd8},
    '{1'b0, -10'sd127, 27'h4000000, 2'd0, 1'b0, 1'b1, 32'h00400000, 3'b010, 4'd8},
    '{1'b0, -10'sd149, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00000001, 3'b000, 4'd8},
    // R7 inexact denormals with sticky shift
    '{1'b0, -10'sd127, 27'h4000001, 2'd0, 1'b0, 1'b0, 32'h00400000, 3'b110, 4'd7},
    '{1'b0, -10'sd150, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00000000, 3'b110, 4'd7},
    '{1'b0, -10'sd150, 27'h4000000, 2'd2, 1'b0, 1'b0, 32'h00000001, 3'b110, 4'd7},
    '{1'b0, -10'sd150, 27'h4000001, 2'd0, 1'b0, 1'b0, 32'h00000001, 3'b110, 4'd7},
    // R9 tiny-after-rounding boundary at -127
    '{1'b0, -10'sd127, 27'h7FFFFFF, 2'd0, 1'b0, 1'b0, 32'h00800000, 3'b100, 4'd9},
    '{1'b0, -10'sd127, 27'h7FFFFFF, 2'd1, 1'b0, 1'b0, 32'h007FFFFF, 3'b110, 4'd9},
    '{1'b1, -10'sd127, 27'h7FFFFFF, 2'd3, 1'b0, 1'b0, 32'h80800000, 3'b100, 4'd9},
    // R10 flush by mode and sign
    '{1'b0, -10'sd127, 27'h4000000, 2'd0, 1'b1, 1'b0, 32'h00000000, 3'b110, 4'd10},
    '{1'b1, -10'sd127, 27'h4000000, 2'd0, 1'b1, 1'b0, 32'h80000000, 3'b110, 4'd10},
    '{1'b0, -10'sd127, 27'h4000000, 2'd2, 1'b1, 1'b0, 32'h00800000, 3'b110, 4'd10},
    '{1'b1, -10'sd127, 27'h4000000, 2'd2, 1'b1, 1'b0, 32'h80000000, 3'b110, 4'd10},
    '{1'b0, -10'sd127, 27'h4000000, 2'd3, 1'b1, 1'b0, 32'h00000000, 3'b110, 4'd10},
    '{1'b1, -10'sd127, 27'h4000000, 2'd3, 1'b1, 1'b0, 32'h80800000, 3'b110, 4'd10},
    '{1'b1, -10'sd127, 27'h4000000, 2'd1, 1'b1, 1'b0, 32'h80000000, 3'b110, 4'd10},
    '{1'b0, -10'sd127, 27'h7FFFFFF, 2'd0, 1'b1, 1'b0, 32'h00000000, 3'b110, 4'd10},
    // R11 deep underflow collapses into the sticky bit
    '{1'b0, -10'sd300, 27'h4000000, 2'd2, 1'b0, 1'b0, 32'h00000001, 3'b110, 4'd11},
    '{1'b0, -10'sd300, 27'h4000000, 2'd0, 1'b0, 1'b0, 32'h00000000, 3'b110, 4'd11},
    '{1'b1, -10'sd512, 27'h4000000, 2'd3, 1'b0, 1'b0, 32'h80000001, 3'b110, 4'd11}
  };

  task automatic check(input string tag, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    @(negedge clk);
    in_valid   = 1'b1;
    in_sign    = v.s;
    in_exp     = v.e;
    in_mant    = v.m;
    rmode      = v.rm;
    flush_en   = v.fz;
    uf_trap_en = v.ut;
    @(negedge clk);
    in_valid = 1'b0;
    check($sformatf("R%0d vec e=%0d m=%h rm=%0d fz=%0b", v.req, v.e, v.m, v.rm, v.fz),
          {out_valid, flag_inexact, flag_underflow, flag_overflow, out_word},
          {1'b1, v.f, v.w});
  endtask

  initial begin
    rst = 1'b1; in_valid = 1'b0; in_sign = 1'b0; in_exp = '0;
    in_mant = 27'h4000000; rmode = 2'd0; flush_en = 1'b0; uf_trap_en = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset state", {out_valid, flag_inexact, flag_underflow, flag_overflow, out_word}, 36'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle after reset", {35'd0, out_valid}, 36'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R1 valid drops one cycle after the last operation
    @(negedge clk);
    check("R1 out_valid falls", {35'd0, out_valid}, 36'd0);

    // R1 back-to-back: overflow then exact, flags refreshed each cycle
    @(negedge clk);
    in_valid = 1'b1; in_sign = 1'b0; in_exp = 10'sd200; in_mant = 27'h4000000;
    rmode = 2'd1; flush_en = 1'b0; uf_trap_en = 1'b0;
    @(negedge clk);
    check("R6 back-to-back overflow", {out_valid, flag_inexact, flag_underflow, flag_overflow, out_word},
          {4'b1101, 32'h7F7FFFFF});
    in_exp = 10'sd1; in_mant = 27'h5000000;
    @(negedge clk);
    check("R1 back-to-back exact", {out_valid, flag_inexact, flag_underflow, flag_overflow, out_word},
          {4'b1000, 32'h40200000});
    in_valid = 1'b0;

    // R1 reset mid-stream clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset clears", {out_valid, flag_inexact, flag_underflow, flag_overflow, out_word}, 36'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule